// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block sits beside a processor's control-register file and turns one accepted exception request into the single-cycle set of state changes that exception entry needs. For each request it works out the handler fetch address, the value to save as the return PC, the branch-delay flag, the 5-bit exception code, the coprocessor number for a coprocessor-unusable fault, and which status bits must be set. It does not hold the status or cause registers itself. The current exception-level, boot-vector and interrupt-vector bits and the programmable vector base come in as inputs. Every update leaves as a value plus a write strobe, and the register file applies the strobed values.

Requests cover the general exception classes, TLB refill, interrupts, cache error, non-maskable interrupt and soft reset. A request is sampled on a rising clock edge. All results appear together on the registered outputs for exactly the following cycle. A request with an exception kind that has no meaning raises an error pulse and asserts no write strobe.

Kind encoding on `kind_i`: for every general exception the kind equals its exception code (0 interrupt, 1 modify, 2 TLB load, 3 TLB store, 4 address error load, 5 address error store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 break, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 15 floating point, 30 cache error). Kind 20 is non-maskable interrupt and 21 is soft reset. Every other value is unrecognised.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, and before any request, every strobe output (redirect_o, error_o and all *_we_o / *_set_o / kernel_o) is 0.
- R2: A general request of kind k asserts code_we_o with code_o = k and asserts redirect_o, all in the cycle after the request edge.
- R3: The handler base is 0xBFC00200 when bev_i = 1, and ebase_i with bits 9:0 cleared when bev_i = 0. The default offset added to it is 0x180.
- R4: An interrupt (kind 0) uses offset 0x200 when iv_i = 1 and 0x180 when iv_i = 0.
- R5: A TLB load or store (kind 2 or 3) with refill_i = 1 uses offset 0x000 only when exl_i = 0. With exl_i = 1, or with refill_i = 0, it uses 0x180.
- R6: A cache error (kind 30) uses offset 0x100 when bev_i = 1 and 0x20000100 when bev_i = 0.
- R7: For a general request with exl_i = 0: epc_we_o = 1, bd_we_o = 1, exl_set_o = 1 and kernel_o = 1. epc_o = pc_i − 4 with bd_o = 1 when in_delay_i = 1; otherwise epc_o = pc_i with bd_o = 0.
- R8: For a general request with exl_i = 1: epc_we_o, bd_we_o, exl_set_o and kernel_o stay 0, while the code and redirect are still produced.
- R9: Coprocessor unusable (kind 11) asserts ce_we_o with ce_o = cop_num_i. No other kind asserts ce_we_o.
- R10: Non-maskable interrupt (kind 20) and soft reset (kind 21) assert errpc_we_o with errpc_o = pc_i, or pc_i − 4 when in_delay_i = 1. They also assert erl_set_o, bev_set_o and kernel_o, and redirect to 0xBFC00000. They assert no epc, bd or code strobe. Kind 20 alone asserts nmi_set_o and kind 21 alone asserts srst_set_o.
- R11: An unrecognised kind asserts error_o for one cycle and asserts neither redirect_o nor any write or set strobe.
- R12: Strobes are single-cycle results of one request. In a cycle whose preceding edge saw req_i = 0, all strobes are 0. Back-to-back requests each give their own result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Exception request, sampled each rising edge |
| kind_i | input | 5 | Exception kind |
| pc_i | input | 32 | PC of the faulting instruction |
| in_delay_i | input | 1 | Faulting instruction sits in a branch delay slot |
| refill_i | input | 1 | TLB miss needs a refill (no matching entry) |
| cop_num_i | input | 2 | Coprocessor number for coprocessor unusable |
| exl_i | input | 1 | Current exception-level bit |
| bev_i | input | 1 | Current boot-vector bit |
| iv_i | input | 1 | Current interrupt-vector cause bit |
| ebase_i | input | 32 | Programmable exception base |
| redirect_o | output | 1 | Fetch must restart at target_pc_o |
| target_pc_o | output | 32 | Handler fetch address |
| epc_we_o | output | 1 | Write strobe for the exception PC |
| epc_o | output | 32 | Exception PC value |
| bd_we_o | output | 1 | Write strobe for the branch-delay cause bit |
| bd_o | output | 1 | Branch-delay cause bit value |
| code_we_o | output | 1 | Write strobe for the exception-code field |
| code_o | output | 5 | Exception-code value |
| ce_we_o | output | 1 | Write strobe for the coprocessor-number field |
| ce_o | output | 2 | Coprocessor-number value |
| errpc_we_o | output | 1 | Write strobe for the error PC |
| errpc_o | output | 32 | Error PC value |
| exl_set_o | output | 1 | Set the exception-level bit |
| erl_set_o | output | 1 | Set the error-level bit |
| bev_set_o | output | 1 | Set the boot-vector bit |
| nmi_set_o | output | 1 | Set the non-maskable interrupt status flag |
| srst_set_o | output | 1 | Set the soft-reset status flag |
| kernel_o | output | 1 | Force the operating mode to kernel |
| error_o | output | 1 | Unrecognised exception kind |

## Verification
The hardest case to reach is a nested exception, where the exception-level bit is already set. The block must then withhold the saved-PC, branch-delay and mode strobes while it still redirects with a code, and a TLB refill must stop using its dedicated offset. Because the status bits are inputs, the stimulus drives exl_i high on TLB load and store refills, on delay-slot faults and on ordinary faults. It compares these results against the same requests made with exl_i low. Cache error is also exercised under both boot-vector settings, and two requests are issued on consecutive edges to show that results do not merge.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int KIND_W = 5;
  localparam int CODE_W = 5;
  localparam int CE_W   = 2;

  typedef enum logic [1:0] {
    CLS_GENERAL,
    CLS_ERRLVL,
    CLS_INVALID
  } exc_cls_e;

  typedef enum logic [1:0] {
    VOFS_DEFAULT,
    VOFS_INTR,
    VOFS_REFILL,
    VOFS_CACHE
  } vofs_e;

  localparam logic [KIND_W-1:0] K_INT   = 5'd0;
  localparam logic [KIND_W-1:0] K_MOD   = 5'd1;
  localparam logic [KIND_W-1:0] K_TLBL  = 5'd2;
  localparam logic [KIND_W-1:0] K_TLBS  = 5'd3;
  localparam logic [KIND_W-1:0] K_ADEL  = 5'd4;
  localparam logic [KIND_W-1:0] K_ADES  = 5'd5;
  localparam logic [KIND_W-1:0] K_IBE   = 5'd6;
  localparam logic [KIND_W-1:0] K_DBE   = 5'd7;
  localparam logic [KIND_W-1:0] K_SYS   = 5'd8;
  localparam logic [KIND_W-1:0] K_BRK   = 5'd9;
  localparam logic [KIND_W-1:0] K_RI    = 5'd10;
  localparam logic [KIND_W-1:0] K_CPU   = 5'd11;
  localparam logic [KIND_W-1:0] K_OVF   = 5'd12;
  localparam logic [KIND_W-1:0] K_TRAP  = 5'd13;
  localparam logic [KIND_W-1:0] K_FPE   = 5'd15;
  localparam logic [KIND_W-1:0] K_NMI   = 5'd20;
  localparam logic [KIND_W-1:0] K_SRST  = 5'd21;
  localparam logic [KIND_W-1:0] K_CACHE = 5'd30;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  input  logic              exl_i,
  input  logic              iv_i,
  input  logic              refill_i,
  output exc_cls_e          cls_o,
  output vofs_e             vofs_o,
  output logic [CODE_W-1:0] code_o,
  output logic              is_cpu_o,
  output logic              is_nmi_o,
  output logic              is_srst_o
);
  always_comb begin
    cls_o     = CLS_INVALID;
    vofs_o    = VOFS_DEFAULT;
    code_o    = CODE_W'(kind_i);
    is_cpu_o  = 1'b0;
    is_nmi_o  = 1'b0;
    is_srst_o = 1'b0;
    unique case (kind_i)
      K_INT: begin
        cls_o  = CLS_GENERAL;
        vofs_o = iv_i ? VOFS_INTR : VOFS_DEFAULT;
      end
      K_TLBL, K_TLBS: begin
        cls_o  = CLS_GENERAL;
        // dedicated refill slot only outside a nested exception
        vofs_o = (refill_i && !exl_i) ? VOFS_REFILL : VOFS_DEFAULT;
      end
      K_CPU: begin
        cls_o    = CLS_GENERAL;
        is_cpu_o = 1'b1;
      end
      K_CACHE: begin
        cls_o  = CLS_GENERAL;
        vofs_o = VOFS_CACHE;
      end
      K_MOD, K_ADEL, K_ADES, K_IBE, K_DBE, K_SYS, K_BRK, K_RI,
      K_OVF, K_TRAP, K_FPE: begin
        cls_o = CLS_GENERAL;
      end
      K_NMI: begin
        cls_o    = CLS_ERRLVL;
        is_nmi_o = 1'b1;
      end
      K_SRST: begin
        cls_o     = CLS_ERRLVL;
        is_srst_o = 1'b1;
      end
      default: cls_o = CLS_INVALID;
    endcase
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int              AW             = 32,
  parameter int              EBASE_LSB      = 10,
  parameter logic [AW-1:0]   BOOT_BASE      = 32'hBFC0_0200,
  parameter logic [AW-1:0]   ERRLVL_VEC     = 32'hBFC0_0000,
  parameter logic [AW-1:0]   OFS_DEFAULT    = 32'h0000_0180,
  parameter logic [AW-1:0]   OFS_INTR       = 32'h0000_0200,
  parameter logic [AW-1:0]   OFS_REFILL     = 32'h0000_0000,
  parameter logic [AW-1:0]   OFS_CACHE_BOOT = 32'h0000_0100,
  parameter logic [AW-1:0]   OFS_CACHE_RUN  = 32'h2000_0100
) (
  input  exc_cls_e        cls_i,
  input  vofs_e           vofs_i,
  input  logic            bev_i,
  input  logic [AW-1:0]   ebase_i,
  output logic [AW-1:0]   target_o
);
  localparam logic [AW-1:0] BASE_MASK = {{(AW-EBASE_LSB){1'b1}}, {EBASE_LSB{1'b0}}};

  logic [AW-1:0] base;
  logic [AW-1:0] ofs;

  assign base = bev_i ? BOOT_BASE : (ebase_i & BASE_MASK);

  always_comb begin
    unique case (vofs_i)
      VOFS_INTR:   ofs = OFS_INTR;
      VOFS_REFILL: ofs = OFS_REFILL;
      VOFS_CACHE:  ofs = bev_i ? OFS_CACHE_BOOT : OFS_CACHE_RUN;
      default:     ofs = OFS_DEFAULT;
    endcase
  end

  assign target_o = (cls_i == CLS_ERRLVL) ? ERRLVL_VEC : base + ofs;
endmodule

// File: rtl/exc_save_gen.sv
module exc_save_gen #(
  parameter int AW          = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic [AW-1:0] pc_i,
  input  logic          in_delay_i,
  output logic [AW-1:0] save_pc_o,
  output logic          bd_o
);
  localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

  // return to the branch when faulting in its delay slot
  assign save_pc_o = in_delay_i ? pc_i - STEP : pc_i;
  assign bd_o      = in_delay_i;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int AW          = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [4:0]        kind_i,
  input  logic [AW-1:0]     pc_i,
  input  logic              in_delay_i,
  input  logic              refill_i,
  input  logic [1:0]        cop_num_i,
  input  logic              exl_i,
  input  logic              bev_i,
  input  logic              iv_i,
  input  logic [AW-1:0]     ebase_i,
  output logic              redirect_o,
  output logic [AW-1:0]     target_pc_o,
  output logic              epc_we_o,
  output logic [AW-1:0]     epc_o,
  output logic              bd_we_o,
  output logic              bd_o,
  output logic              code_we_o,
  output logic [4:0]        code_o,
  output logic              ce_we_o,
  output logic [1:0]        ce_o,
  output logic              errpc_we_o,
  output logic [AW-1:0]     errpc_o,
  output logic              exl_set_o,
  output logic              erl_set_o,
  output logic              bev_set_o,
  output logic              nmi_set_o,
  output logic              srst_set_o,
  output logic              kernel_o,
  output logic              error_o
);
  exc_cls_e          cls;
  vofs_e             vofs;
  logic [CODE_W-1:0] code_d;
  logic              is_cpu, is_nmi, is_srst;
  logic [AW-1:0]     target_d, save_pc;
  logic              save_bd;

  exc_classify u_cls (
    .kind_i    (kind_i),
    .exl_i     (exl_i),
    .iv_i      (iv_i),
    .refill_i  (refill_i),
    .cls_o     (cls),
    .vofs_o    (vofs),
    .code_o    (code_d),
    .is_cpu_o  (is_cpu),
    .is_nmi_o  (is_nmi),
    .is_srst_o (is_srst)
  );

  exc_vector_gen #(.AW(AW)) u_vec (
    .cls_i    (cls),
    .vofs_i   (vofs),
    .bev_i    (bev_i),
    .ebase_i  (ebase_i),
    .target_o (target_d)
  );

  exc_save_gen #(.AW(AW), .INSTR_BYTES(INSTR_BYTES)) u_save (
    .pc_i       (pc_i),
    .in_delay_i (in_delay_i),
    .save_pc_o  (save_pc),
    .bd_o       (save_bd)
  );

  logic gen_ok, err_ok, bad, fresh;
  assign gen_ok = req_i && (cls == CLS_GENERAL);
  assign err_ok = req_i && (cls == CLS_ERRLVL);
  assign bad    = req_i && (cls == CLS_INVALID);
  assign fresh  = gen_ok && !exl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o  <= 1'b0;
      target_pc_o <= '0;
      epc_we_o    <= 1'b0;
      epc_o       <= '0;
      bd_we_o     <= 1'b0;
      bd_o        <= 1'b0;
      code_we_o   <= 1'b0;
      code_o      <= '0;
      ce_we_o     <= 1'b0;
      ce_o        <= '0;
      errpc_we_o  <= 1'b0;
      errpc_o     <= '0;
      exl_set_o   <= 1'b0;
      erl_set_o   <= 1'b0;
      bev_set_o   <= 1'b0;
      nmi_set_o   <= 1'b0;
      srst_set_o  <= 1'b0;
      kernel_o    <= 1'b0;
      error_o     <= 1'b0;
    end else begin
      redirect_o  <= gen_ok || err_ok;
      target_pc_o <= (gen_ok || err_ok) ? target_d : '0;
      epc_we_o    <= fresh;
      epc_o       <= fresh ? save_pc : '0;
      bd_we_o     <= fresh;
      bd_o        <= fresh && save_bd;
      code_we_o   <= gen_ok;
      code_o      <= gen_ok ? code_d : '0;
      ce_we_o     <= gen_ok && is_cpu;
      ce_o        <= (gen_ok && is_cpu) ? cop_num_i : '0;
      errpc_we_o  <= err_ok;
      errpc_o     <= err_ok ? save_pc : '0;
      exl_set_o   <= fresh;
      erl_set_o   <= err_ok;
      bev_set_o   <= err_ok;
      nmi_set_o   <= err_ok && is_nmi;
      srst_set_o  <= err_ok && is_srst;
      kernel_o    <= fresh || err_ok;
      error_o     <= bad;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [4:0]    kind_i,
  input logic [AW-1:0] pc_i,
  input logic          exl_i,
  input logic          redirect_o,
  input logic [AW-1:0] target_pc_o,
  input logic          epc_we_o,
  input logic [AW-1:0] epc_o,
  input logic          bd_we_o,
  input logic          bd_o,
  input logic          code_we_o,
  input logic [4:0]    code_o,
  input logic          ce_we_o,
  input logic          errpc_we_o,
  input logic          exl_set_o,
  input logic          erl_set_o,
  input logic          bev_set_o,
  input logic          kernel_o,
  input logic          error_o
);
  a_r12_idle_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(redirect_o || error_o || epc_we_o || errpc_we_o || code_we_o || kernel_o));

  a_r11_error_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !(redirect_o || epc_we_o || bd_we_o || code_we_o || errpc_we_o || exl_set_o));

  a_r8_nested_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && exl_i && kind_i != 5'd20 && kind_i != 5'd21) |=>
      !(epc_we_o || bd_we_o || exl_set_o || kernel_o));

  a_r7_epc_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epc_we_o |-> (epc_o == (bd_o ? $past(pc_i) - AW'(4) : $past(pc_i))));

  a_r10_errlvl_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    errpc_we_o |-> (target_pc_o == 32'hBFC0_0000 && erl_set_o && bev_set_o && kernel_o && !code_we_o));

  a_r3_vector_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !errpc_we_o) |-> (target_pc_o[6:0] == 7'd0));

  a_r9_ce_only_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_we_o |-> (code_we_o && code_o == 5'd11));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW)) u_chk (.*);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  typedef struct {
    string       tag;
    logic        redirect;
    logic [31:0] target;
    logic        epc_we;
    logic [31:0] epc;
    logic        bd_we;
    logic        bd;
    logic        code_we;
    logic [4:0]  code;
    logic        ce_we;
    logic [1:0]  ce;
    logic        errpc_we;
    logic [31:0] errpc;
    logic        exl_set, erl_set, bev_set, nmi_set, srst_set, kernel, error;
  } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [4:0] kind_i = '0;
  logic [31:0] pc_i = '0, ebase_i = '0;
  logic in_delay_i = 1'b0, refill_i = 1'b0, exl_i = 1'b0, bev_i = 1'b0, iv_i = 1'b0;
  logic [1:0] cop_num_i = '0;

  logic redirect_o, epc_we_o, bd_we_o, bd_o, code_we_o, ce_we_o, errpc_we_o;
  logic exl_set_o, erl_set_o, bev_set_o, nmi_set_o, srst_set_o, kernel_o, error_o;
  logic [31:0] target_pc_o, epc_o, errpc_o;
  logic [4:0] code_o;
  logic [1:0] ce_o;

  int checks = 0, errors = 0;
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  exc_entry_ctrl u_dut (.*);

  function automatic exp_t model(string tag, logic [4:0] k, logic [31:0] pc, logic dly,
                                 logic rf, logic [1:0] cop, logic exl, logic bev,
                                 logic iv, logic [31:0] eb);
    exp_t e;
    logic [31:0] base, ofs, sv;
    logic gen;
    e = '{tag: tag, default: '0};
    gen = (k <= 13) || k == 15 || k == 30;
    sv = dly ? pc - 32'd4 : pc;
    base = bev ? 32'hBFC0_0200 : {eb[31:10], 10'd0};
    ofs = 32'h180;
    if (k == 0 && iv) ofs = 32'h200;
    if ((k == 2 || k == 3) && rf && !exl) ofs = 32'h0;
    if (k == 30) ofs = bev ? 32'h100 : 32'h2000_0100;
    if (gen) begin
      e.redirect = 1; e.target = base + ofs;
      e.code_we = 1; e.code = k;
      if (!exl) begin
        e.epc_we = 1; e.epc = sv; e.bd_we = 1; e.bd = dly;
        e.exl_set = 1; e.kernel = 1;
      end
      if (k == 11) begin e.ce_we = 1; e.ce = cop; end
    end else if (k == 20 || k == 21) begin
      e.redirect = 1; e.target = 32'hBFC0_0000;
      e.errpc_we = 1; e.errpc = sv;
      e.erl_set = 1; e.bev_set = 1; e.kernel = 1;
      e.nmi_set = (k == 20); e.srst_set = (k == 21);
    end else begin
      e.error = 1;
    end
    return e;
  endfunction

  task automatic drive(string tag, logic [4:0] k, logic [31:0] pc, logic dly, logic rf,
                       logic [1:0] cop, logic exl, logic bev, logic iv, logic [31:0] eb);
    @(negedge clk_i);
    req_i = 1; kind_i = k; pc_i = pc; in_delay_i = dly; refill_i = rf;
    cop_num_i = cop; exl_i = exl; bev_i = bev; iv_i = iv; ebase_i = eb;
    q.push_back(model(tag, k, pc, dly, rf, cop, exl, bev, iv, eb));
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic fail1(string tag, string f, logic [31:0] act, logic [31:0] exp);
    $display("FAIL %s field %s: actual %h expected %h", tag, f, act, exp);
  endtask

  task automatic check_idle(string tag);
    logic any;
    any = redirect_o | error_o | epc_we_o | bd_we_o | code_we_o | ce_we_o | errpc_we_o |
          exl_set_o | erl_set_o | bev_set_o | nmi_set_o | srst_set_o | kernel_o;
    checks++;
    if (any) begin errors++; fail1(tag, "strobes", 32'(any), 32'h0); end
  endtask

  // monitor: compare every produced result against the queue head
  initial begin
    forever begin
      @(negedge clk_i); #1;
      if (rst_ni && (redirect_o | error_o | epc_we_o | errpc_we_o | code_we_o | kernel_o)) begin
        exp_t e;
        int bad;
        checks++;
        bad = 0;
        if (q.size() == 0) begin
          errors++; fail1("R12 unexpected", "result", 32'h1, 32'h0);
        end else begin
          e = q.pop_front();
          if (redirect_o !== e.redirect) begin bad++; fail1(e.tag, "redirect", 32'(redirect_o), 32'(e.redirect)); end
          if (e.redirect && target_pc_o !== e.target) begin bad++; fail1(e.tag, "target", target_pc_o, e.target); end
          if (epc_we_o !== e.epc_we) begin bad++; fail1(e.tag, "epc_we", 32'(epc_we_o), 32'(e.epc_we)); end
          if (e.epc_we && epc_o !== e.epc) begin bad++; fail1(e.tag, "epc", epc_o, e.epc); end
          if (bd_we_o !== e.bd_we) begin bad++; fail1(e.tag, "bd_we", 32'(bd_we_o), 32'(e.bd_we)); end
          if (e.bd_we && bd_o !== e.bd) begin bad++; fail1(e.tag, "bd", 32'(bd_o), 32'(e.bd)); end
          if (code_we_o !== e.code_we) begin bad++; fail1(e.tag, "code_we", 32'(code_we_o), 32'(e.code_we)); end
          if (e.code_we && code_o !== e.code) begin bad++; fail1(e.tag, "code", 32'(code_o), 32'(e.code)); end
          if (ce_we_o !== e.ce_we) begin bad++; fail1(e.tag, "ce_we", 32'(ce_we_o), 32'(e.ce_we)); end
          if (e.ce_we && ce_o !== e.ce) begin bad++; fail1(e.tag, "ce", 32'(ce_o), 32'(e.ce)); end
          if (errpc_we_o !== e.errpc_we) begin bad++; fail1(e.tag, "errpc_we", 32'(errpc_we_o), 32'(e.errpc_we)); end
          if (e.errpc_we && errpc_o !== e.errpc) begin bad++; fail1(e.tag, "errpc", errpc_o, e.errpc); end
          if ({exl_set_o, erl_set_o, bev_set_o, nmi_set_o, srst_set_o, kernel_o, error_o} !==
              {e.exl_set, e.erl_set, e.bev_set, e.nmi_set, e.srst_set, e.kernel, e.error}) begin
            bad++;
            fail1(e.tag, "status_set", 32'({exl_set_o, erl_set_o, bev_set_o, nmi_set_o, srst_set_o, kernel_o, error_o}),
                  32'({e.exl_set, e.erl_set, e.bev_set, e.nmi_set, e.srst_set, e.kernel, e.error}));
          end
          if (bad != 0) errors++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_idle("R1 reset");
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    check_idle("R1 after reset");

    // R2 R7: every general kind, exl clear
    foreach (q[i]) ;
    for (int k = 0; k < 32; k++) begin
      if (k <= 13 || k == 15 || k == 30) begin
        drive("R2 code map", 5'(k), 32'h0040_1000 + 32'(k * 16), 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
        idle();
      end
    end
    // R3 base from ebase low bits cleared, R7 delay slot rewind
    drive("R3 R7 syscall ebase", 5'd8, 32'h0040_2000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h8000_13FF);
    idle();
    drive("R7 break delay slot", 5'd9, 32'h0040_2004, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    drive("R3 boot base overflow", 5'd12, 32'h0040_3000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h8000_0000);
    idle();
    // R4
    drive("R4 intr iv1", 5'd0, 32'h0040_4000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h9000_0400);
    idle();
    drive("R4 intr iv0", 5'd0, 32'h0040_4000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h9000_0400);
    idle();
    // R5 R8 refill vs nested
    drive("R5 tlbl refill", 5'd2, 32'h0040_5000, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    drive("R5 R8 tlbs refill nested", 5'd3, 32'h0040_5004, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    drive("R5 tlbl no refill", 5'd2, 32'h0040_5008, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h8000_0000);
    idle();
    drive("R8 nested delay ri", 5'd10, 32'h0040_500C, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    // R6
    drive("R6 cache boot", 5'd30, 32'h0040_6000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h8000_0000);
    idle();
    drive("R6 cache run", 5'd30, 32'h0040_6004, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    // R9
    drive("R9 cpu cop2", 5'd11, 32'h0040_7000, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    drive("R9 cpu cop3 nested", 5'd11, 32'h0040_7004, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    // R10
    drive("R10 nmi delay", 5'd20, 32'h0040_8004, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    drive("R10 soft reset", 5'd21, 32'h0040_8100, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    // R11
    drive("R11 kind 14", 5'd14, 32'h0040_9000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    drive("R11 kind 31", 5'd31, 32'h0040_9004, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    // R12 back to back, then idle
    drive("R12 first", 5'd4, 32'h0040_A000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
    drive("R12 second", 5'd21, 32'h0040_A004, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
    drive("R12 third", 5'd5, 32'h0040_A008, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h8000_0000);
    idle();
    repeat (2) @(negedge clk_i);
    check_idle("R12 idle after burst");

    checks++;
    if (q.size() != 0) begin
      errors++;
      fail1("R12 missing results", "queue", 32'(q.size()), 32'h0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule